// File: doc/BRIEF.md
# Self-Selecting Bus Arbitration Agent

This block is the part of one bus master that takes part in a distributed, self-selecting arbitration on a shared multi-master bus. No central arbiter picks the winner. Each agent holds a priority level. While the arbitration window is open and its session is active, the agent places that level on a set of shared open-drain lines. Every line resolves as the wired-AND of all drivers, and the lowest numeric level wins.

The agent walks its level from the most significant bit down. A 0 bit pulls its line low. A 1 bit releases its line and lets the pull-up take it high. When the agent has released a line but reads it low, a stronger contender is present. From that point on the agent withdraws from every lower-order line. If the agent finishes the walk without losing a bit, it raises a won flag.

The block only emits drive-low enables and never drives a line high. The surrounding pads, or a testbench, merge these enables into the wired-AND bus. A grant register is clocked directly by the address-latch strobe and captures the won flag. A separate open-drain preempt line asks the current owner to give up the bus.

Top module: `arbp_participant`

## Requirements
- R1: No arbitration line whose level bit is 1 is ever pulled low, whether the agent is idle, contending or has lost. `arb_drive_low_o[i]` is 1 only when `level_i[i]` is 0.
- R2: When `session_i` or `arb_window_i` is low, the agent does not participate. All bits of `arb_drive_low_o` are 0 and `won_o` is 0.
- R3: While the agent participates and has lost no higher bit, it pulls low exactly the lines whose level bit is 0. With no other contender, `arb_drive_low_o` equals the bitwise inverse of `level_i`.
- R4: A loss at bit i means the agent released the line (level bit 1) while the resolved bus bit reads 0. After a loss at bit i, the agent releases every bit below i.
- R5: While participating, `won_o` is 1 if and only if the agent loses at no bit position, including bit 0. Among contenders, the lowest numeric level wins, and contenders with an equal lowest level all see `won_o` high.
- R6: A lone agent at level 0001 wins exactly when resolved bus bit 0 reads high. A line held low from outside makes it lose.
- R7: `grant_o` is 0 after reset. On each rising edge of `latch_clk`, the grant register loads the value `won_o` has at that edge.
- R8: `grant_o` is 0 whenever `session_i` is low, even between strobes.
- R9: `preempt_drive_low_o` is 1 exactly while `preempt_req_i` and `session_i` are both high. Otherwise the preempt line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| latch_clk | input | 1 | Address-latch strobe; its rising edge clocks the grant register |
| rst_n | input | 1 | Asynchronous active-low reset |
| session_i | input | 1 | Bus request / session active |
| arb_window_i | input | 1 | Arbitration window open |
| level_i | input | LVL_W | Priority level of this agent (lower value wins) |
| preempt_req_i | input | 1 | Request to preempt the current bus owner |
| arb_bus_i | input | LVL_W | Resolved wired-AND value of the arbitration lines |
| arb_drive_low_o | output | LVL_W | Per-line pull-low enable (1 = pull low, 0 = release) |
| preempt_drive_low_o | output | 1 | Pull-low enable for the preempt line |
| won_o | output | 1 | Agent has won the current arbitration |
| grant_o | output | 1 | Registered grant, held while the session lasts |

## Verification
The bench builds the block with the default four-bit level. At that width the bench can sweep all 256 pairings of the agent's level against a second contender, and every tie, every first-loss bit position and every dropout pattern is reached. The bench closes the wired-AND loop itself. It settles the bus by iterating over behavioural contender models and an optional externally jammed line, and it checks on every cycle that no released line is ever pulled. Scenarios with two and three contenders, a stuck-low line, a session that ends between strobes and preempt requests cover the remaining requirements.

// File: rtl/arbp_pkg.sv
package arbp_pkg;

    // Register state of the grant capture path.
    typedef struct packed {
        logic grant;
    } grant_state_t;

endpackage

// File: rtl/arbp_lane.sv
module arbp_lane #(
    parameter int LVL_W = 4
) (
    input  logic             part_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] bus_i,
    output logic [LVL_W-1:0] drive_low_o,
    output logic             won_o
);

    logic [LVL_W-1:0] lost;      // released this bit but bus reads low
    logic [LVL_W-1:0] dropped;   // a higher bit was already lost
    logic             lost_any;

    // Per-bit loss detection.
    always_comb begin
        lost = part_i ? (level_i & ~bus_i) : '0;
    end

    // Cumulative dropout, MSB first.
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = LVL_W - 1; i >= 0; i--) begin
            dropped[i] = acc;
            acc        = acc | lost[i];
        end
        lost_any = acc;
    end

    // Release term: idle, own bit is 1, or withdrawn after a higher loss.
    always_comb begin
        for (int i = 0; i < LVL_W; i++) begin
            drive_low_o[i] = ~(~part_i | level_i[i] | dropped[i]);
        end
    end

    assign won_o = part_i & ~lost_any;

endmodule

// File: rtl/arbp_grant_reg.sv
module arbp_grant_reg
    import arbp_pkg::*;
(
    input  logic latch_clk,
    input  logic rst_n,
    input  logic won_i,
    output logic grant_q_o
);

    grant_state_t st_d;
    grant_state_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.grant = won_i;
    end

    always_ff @(posedge latch_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_q_o = st_q.grant;

endmodule

// File: rtl/arbp_participant.sv
module arbp_participant #(
    parameter int LVL_W = 4
) (
    input  logic             latch_clk,
    input  logic             rst_n,
    input  logic             session_i,
    input  logic             arb_window_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             preempt_req_i,
    input  logic [LVL_W-1:0] arb_bus_i,
    output logic [LVL_W-1:0] arb_drive_low_o,
    output logic             preempt_drive_low_o,
    output logic             won_o,
    output logic             grant_o
);

    logic participate;
    logic grant_q;

    assign participate = session_i & arb_window_i;

    arbp_lane #(
        .LVL_W(LVL_W)
    ) u_lane (
        .part_i      (participate),
        .level_i     (level_i),
        .bus_i       (arb_bus_i),
        .drive_low_o (arb_drive_low_o),
        .won_o       (won_o)
    );

    arbp_grant_reg u_grant (
        .latch_clk (latch_clk),
        .rst_n     (rst_n),
        .won_i     (won_o),
        .grant_q_o (grant_q)
    );

    assign grant_o             = grant_q & session_i;
    assign preempt_drive_low_o = preempt_req_i & session_i;

endmodule

// File: rtl/arbp_participant_chk.sv
module arbp_participant_chk #(
    parameter int LVL_W = 4
) (
    input logic             latch_clk,
    input logic             rst_n,
    input logic             session_i,
    input logic             arb_window_i,
    input logic [LVL_W-1:0] level_i,
    input logic             preempt_req_i,
    input logic [LVL_W-1:0] arb_bus_i,
    input logic [LVL_W-1:0] arb_drive_low_o,
    input logic             preempt_drive_low_o,
    input logic             won_o,
    input logic             grant_o
);

    a_r1_never_pull_one: assert property (@(posedge latch_clk) disable iff (!rst_n)
        (arb_drive_low_o & level_i) == '0);

    a_r2_idle_release: assert property (@(posedge latch_clk) disable iff (!rst_n)
        !(session_i && arb_window_i) |-> (arb_drive_low_o == '0 && !won_o));

    a_r7_grant_capture: assert property (@(posedge latch_clk) disable iff (!rst_n)
        $past(rst_n) |-> (grant_o == ($past(won_o) && session_i)));

    a_r8_grant_needs_session: assert property (@(posedge latch_clk) disable iff (!rst_n)
        !session_i |-> !grant_o);

    a_r9_preempt_drive: assert property (@(posedge latch_clk) disable iff (!rst_n)
        preempt_drive_low_o == (preempt_req_i && session_i));

    // R4: after a loss at bit i, every lower bit is released.
    for (genvar gi = 1; gi < LVL_W; gi++) begin : g_drop
        localparam logic [LVL_W-1:0] LowMask = LVL_W'((1 << gi) - 1);
        a_r4_lower_released: assert property (@(posedge latch_clk) disable iff (!rst_n)
            (session_i && arb_window_i && level_i[gi] && !arb_bus_i[gi])
                |-> ((arb_drive_low_o & LowMask) == '0));
    end

endmodule

bind arbp_participant arbp_participant_chk #(.LVL_W(LVL_W)) u_chk (
    .latch_clk           (latch_clk),
    .rst_n               (rst_n),
    .session_i           (session_i),
    .arb_window_i        (arb_window_i),
    .level_i             (level_i),
    .preempt_req_i       (preempt_req_i),
    .arb_bus_i           (arb_bus_i),
    .arb_drive_low_o     (arb_drive_low_o),
    .preempt_drive_low_o (preempt_drive_low_o),
    .won_o               (won_o),
    .grant_o             (grant_o)
);

// File: tb/arbp_participant_tb_top.sv
`timescale 1ns / 10ps
module arbp_participant_tb_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         latch_clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         session = 1'b0;
    logic         window = 1'b0;
    logic [W-1:0] level = '0;
    logic         pre_req = 1'b0;
    logic [W-1:0] arb_bus = '1;
    logic [W-1:0] drive_low;
    logic         pre_low;
    logic         won;
    logic         grant;

    int           checks = 0;
    int           errors = 0;
    bit           chk_en = 1'b0;
    bit           done = 1'b0;
    bit           model_grant = 1'b0;
    logic [W-1:0] jam = '0;
    int           others[$];

    always #2 clk = ~clk;   // 250 MHz

    arbp_participant #(.LVL_W(W)) dut_i (
        .latch_clk           (latch_clk),
        .rst_n               (rst_n),
        .session_i           (session),
        .arb_window_i        (window),
        .level_i             (level),
        .preempt_req_i       (pre_req),
        .arb_bus_i           (arb_bus),
        .arb_drive_low_o     (drive_low),
        .preempt_drive_low_o (pre_low),
        .won_o               (won),
        .grant_o             (grant)
    );

    // Behavioural contender: MSB-first walk, withdraw after first loss.
    function automatic logic [W-1:0] walk_drive(input logic [W-1:0] lvl,
                                                input logic [W-1:0] bus, input bit part);
        logic [W-1:0] d;
        bit out;
        d = '0;
        out = 1'b0;
        if (!part) return '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!out) begin
                if (!lvl[i]) d[i] = 1'b1;
                else if (!bus[i]) out = 1'b1;
            end
        end
        return d;
    endfunction

    function automatic bit walk_won(input logic [W-1:0] lvl,
                                    input logic [W-1:0] bus, input bit part);
        bit out;
        out = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!out && lvl[i] && !bus[i]) out = 1'b1;
        end
        return part && !out;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Close the wired-AND loop with the other contenders and any jammed line.
    task automatic settle();
        for (int n = 0; n < 2 * W + 2; n++) begin
            logic [W-1:0] oth;
            oth = jam;
            foreach (others[k]) oth |= walk_drive(W'(others[k]), arb_bus, 1'b1);
            arb_bus = ~(oth | drive_low);
            #0.05;
        end
    endtask

    task automatic step(input logic [W-1:0] lvl, input bit s, input bit w,
                        input bit p, input bit strobe);
        @(posedge clk);
        level = lvl;
        session = s;
        window = w;
        pre_req = p;
        settle();
        if (strobe) begin
            #0.1 latch_clk = 1'b1;
            #0.3 latch_clk = 1'b0;
        end
    endtask

    // Grant reference.
    always @(posedge latch_clk or negedge rst_n) begin
        if (!rst_n) model_grant = 1'b0;
        else model_grant = walk_won(level, arb_bus, session && window);
    end

    // Per-cycle comparison against the reference model.
    always @(negedge clk) begin
        if (chk_en) begin
            bit part;
            logic [W-1:0] exp_d;
            part  = session && window;
            exp_d = walk_drive(level, arb_bus, part);
            check((drive_low & level) == '0, "R1", int'(drive_low), int'(drive_low & ~level));
            if (!part) check(drive_low == '0 && !won, "R2", int'({won, drive_low}), 0);
            else if (exp_d == ~level) check(drive_low == exp_d, "R3", int'(drive_low), int'(exp_d));
            else check(drive_low == exp_d, "R4", int'(drive_low), int'(exp_d));
            check(won == walk_won(level, arb_bus, part), "R5", int'(won),
                  int'(walk_won(level, arb_bus, part)));
            check(grant == (model_grant && session), "R7", int'(grant),
                  int'(model_grant && session));
            if (!session) check(!grant, "R8", int'(grant), 0);
            check(pre_low == (pre_req && session), "R9", int'(pre_low), int'(pre_req && session));
        end
    end

    function automatic int min_other();
        int m;
        m = 1 << W;
        foreach (others[k]) if (others[k] < m) m = others[k];
        return m;
    endfunction

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5;
        check(grant == 1'b0 && drive_low == '0 && !pre_low, "R7 reset", int'(grant), 0);
        rst_n = 1'b1;
        chk_en = 1'b1;

        // Idle agent with level 0001: nothing pulled.
        step(4'b0001, 1'b0, 1'b0, 1'b0, 1'b1);
        step(4'b0001, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check(drive_low == '0, "R2 idle", int'(drive_low), 0);

        // Lone contender at 0001 wins; grant follows strobe.
        step(4'b0001, 1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check(won == 1'b1 && arb_bus[0], "R6 solo win", int'(won), 1);
        check(drive_low == 4'b1110, "R3 solo pattern", int'(drive_low), 4'he);
        check(grant == 1'b1, "R7 grant set", int'(grant), 1);

        // Session ends: grant drops at once.
        step(4'b0001, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check(grant == 1'b0, "R8 session end", int'(grant), 0);

        // Line 0 held low from outside: the lone agent loses.
        jam = 4'b0001;
        step(4'b0001, 1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check(won == 1'b0, "R6 jammed", int'(won), 0);
        check(grant == 1'b0, "R7 grant clear", int'(grant), 0);
        jam = '0;

        // Loss at bit 2 withdraws bits 1 and 0.
        others.push_back(3);
        step(4'b0101, 1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check(drive_low == 4'b1000, "R4 dropout", int'(drive_low), 8);
        check(won == 1'b0, "R5 lose", int'(won), 0);

        // Three contenders, own lowest.
        others.delete();
        others.push_back(6);
        others.push_back(9);
        step(4'b0010, 1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check(won == 1'b1, "R5 lowest wins", int'(won), 1);

        // Tie.
        others.delete();
        others.push_back(5);
        step(4'b0101, 1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check(won == 1'b1, "R5 tie", int'(won), 1);

        // Preempt request with and without session.
        step(4'b0101, 1'b1, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check(pre_low == 1'b1, "R9 preempt on", int'(pre_low), 1);
        step(4'b0101, 1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check(pre_low == 1'b0, "R9 preempt off", int'(pre_low), 0);

        // Exhaustive two-contender sweep.
        for (int o = 0; o < (1 << W); o++) begin
            for (int x = 0; x < (1 << W); x++) begin
                others.delete();
                others.push_back(x);
                step(W'(o), 1'b1, 1'b1, 1'b0, (x % 3) == 0);
                @(negedge clk);
                check(won == (o <= min_other()), "R5 sweep", int'(won), int'(o <= min_other()));
            end
        end

        step(4'b1111, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule